// File: doc/BRIEF.md
# RTC Extended Control and Status Register

This block is the extended control and status byte of a real-time clock, paired with a small auxiliary RAM. The control byte holds several fields:

- A read-only battery-good bit.
- A read-only update-in-progress bit.
- A burst-enable bit.
- A spare read/write bit.
- A power-pin control bit.
- Three sticky event flags: RAM-clear, wake-up alarm and kickstart.

Each flag is set by its hardware event. Software can also set it by writing 1 and clears it by writing 0. An interrupt is raised when any flag is set together with its enable.

Software uses a synchronous register port with three locations:

- The control byte at address 0.
- The auxiliary RAM pointer at address 1.
- The auxiliary RAM data window at address 2.

When burst mode is on, each access to the data window moves the pointer forward by one. The pointer wraps at the RAM depth. This lets software stream through the RAM without rewriting the pointer.

The update-in-progress bit is raised by an update-pending pulse. It stays high for a lead time plus the length of the update, both counted in clock ticks.

Top module: `rtcx_ctrl`

## Requirements
- R1: After reset, the control byte reads 0x80 when `batt_ok` is 1, the RAM pointer reads 0, `irq` is 0 and `pwr_drive_low` is 1.
- R2: Control byte bit 7 always reads the level of `batt_ok` and ignores writes. Bit 6 (update in progress) also ignores writes.
- R3: Bit 4 is a spare bit that can be written and read back. It changes no other output or bit.
- R4: A one-cycle `upd_soon` pulse makes bit 6 read 1 for exactly LEAD_TICKS+UPD_TICKS cycles, starting with the cycle after the pulse. A pulse that arrives while bit 6 is already 1 is ignored.
- R5: When bit 5 is 1, every read or write of address 2 advances the RAM pointer by one, modulo DEPTH. When bit 5 is 0, the pointer does not move.
- R6: Bit 3 is writable, and `pwr_drive_low` is its inverse.
- R7: Bit 3 is forced to 0 while the wake flag (bit 1) and `irq_en[1]` are both 1, or while the kickstart flag (bit 0) and `irq_en[0]` are both 1. A write of 1 cannot override this.
- R8: The RAM-clear flag (bit 2) is set by a high-to-low transition of `ram_clr_n` only when `ram_clr_en` is 1. A held low level does not set it again.
- R9: A `wake_evt` pulse sets bit 1 and a `kick_evt` pulse sets bit 0. Writing 1 to a bit among 2..0 sets that flag and writing 0 clears it.
- R10: When a hardware set and a software clear of the same flag happen in the same cycle, the flag ends up set.
- R11: `irq` is the OR of each flag ANDed with its `irq_en` bit (index 2 is RAM-clear, 1 is wake, 0 is kickstart). It is updated on the same edge as the flags.
- R12: `reg_rdata` is valid in the cycle after `reg_rd` and holds until the next read. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 RAM pointer, 2 RAM data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after reg_rd |
| batt_ok | input | 1 | Auxiliary battery good |
| upd_soon | input | 1 | Pulse: an update cycle is pending |
| ram_clr_n | input | 1 | Asynchronous RAM-clear request, active low |
| ram_clr_en | input | 1 | Enables RAM-clear flag setting |
| wake_evt | input | 1 | Wake-up alarm event pulse |
| kick_evt | input | 1 | Kickstart event pulse |
| irq_en | input | 3 | Interrupt enables {RAM-clear, wake, kickstart} |
| pwr_drive_low | output | 1 | 1 drives the power pin low, 0 releases it |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:

- The forced clearing of the power-control bit under an enabled wake or kickstart flag.
- That a wake event always leaves the flag set.
- The pointer movement, or lack of it, on each data access.
- That the update window opens only after a pending pulse and never exceeds its length.
- That the edge detector emits single-cycle pulses.
- That a read of the control byte reports the battery level.

Other behaviour can only be shown by the bench's scenarios:

- Pointer wrap across the RAM top with data kept intact.
- Reserved-bit isolation.
- Flags ignoring RAM-clear edges while that source is disabled.
- The exact length of the update window.
- That a second pending pulse is ignored while the window is open.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_RADDR = 2'd1,
    SEL_RDATA = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int B_BATT = 7;
  localparam int B_UPD  = 6;
  localparam int B_BRST = 5;
  localparam int B_SPR  = 4;
  localparam int B_PWR  = 3;
  localparam int NFLAG  = 3;   // flag index: 2 RAM-clear, 1 wake, 0 kickstart
endpackage

// File: rtl/rtcx_fall_det.sv
module rtcx_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

  // R8: the detector yields isolated single-cycle pulses
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/rtcx_upd_timer.sv
module rtcx_upd_timer #(
  parameter int LEAD_TICKS = 4,
  parameter int UPD_TICKS  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_soon,
  output logic busy
);
  localparam int TOTAL = LEAD_TICKS + UPD_TICKS;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (upd_soon) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(TOTAL - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;

  // checker-side window counter
  logic [CW:0] hi_len_q;
  always_ff @(posedge clk) begin
    if (rst)         hi_len_q <= '0;
    else if (busy_q) hi_len_q <= hi_len_q + 1'b1;
    else             hi_len_q <= '0;
  end

  // R4: window opens only after a pending pulse
  p_open_after_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(upd_soon));
  // R4: window never longer than lead plus update
  p_window_len_r4: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (hi_len_q < (CW+1)'(TOTAL)));
endmodule

// File: rtl/rtcx_aux_ram.sv
module rtcx_aux_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DW-1:0]            wd,
  output logic [DW-1:0]            rd
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd_q <= mem[addr];
  end

  assign rd = rd_q;
endmodule

// File: rtl/rtcx_ctrl.sv
module rtcx_ctrl
  import rtcx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int LEAD_TICKS = 4,
  parameter int UPD_TICKS  = 3,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              batt_ok,
  input  logic              upd_soon,
  input  logic              ram_clr_n,
  input  logic              ram_clr_en,
  input  logic              wake_evt,
  input  logic              kick_evt,
  input  logic [NFLAG-1:0]  irq_en,
  output logic              pwr_drive_low,
  output logic              irq
);
  localparam int RAW = $clog2(DEPTH);

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic wr_ctrl, wr_ptr, acc_data, rd_data;
  assign wr_ctrl  = reg_wr && (sel == SEL_CTRL);
  assign wr_ptr   = reg_wr && (sel == SEL_RADDR);
  assign rd_data  = reg_rd && (sel == SEL_RDATA);
  assign acc_data = (reg_wr || reg_rd) && (sel == SEL_RDATA);

  // sub-blocks
  logic clr_fall, upd_busy;
  logic [REG_DW-1:0] ram_q;
  logic [RAW-1:0] ptr_q;

  rtcx_fall_det #(.STAGES(SYNC_STG)) u_clr (
    .clk(clk), .rst(rst), .din(ram_clr_n), .fall(clr_fall));

  rtcx_upd_timer #(.LEAD_TICKS(LEAD_TICKS), .UPD_TICKS(UPD_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .upd_soon(upd_soon), .busy(upd_busy));

  rtcx_aux_ram #(.DEPTH(DEPTH), .DW(REG_DW)) u_ram (
    .clk(clk), .we(reg_wr && (sel == SEL_RDATA)), .re(rd_data),
    .addr(ptr_q), .wd(reg_wdata), .rd(ram_q));

  // control state
  logic             brst_q, spr_q, pwr_q, irq_q;
  logic [NFLAG-1:0] flg_q, flg_d, hw_set;
  logic             pwr_d;

  assign hw_set = {clr_fall & ram_clr_en, wake_evt, kick_evt};

  always_comb begin
    for (int i = 0; i < NFLAG; i++)
      flg_d[i] = hw_set[i] | (wr_ctrl ? reg_wdata[i] : flg_q[i]);
    pwr_d = (wr_ctrl ? reg_wdata[B_PWR] : pwr_q)
            & ~(|(flg_d[1:0] & irq_en[1:0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brst_q <= 1'b0;
      spr_q  <= 1'b0;
      pwr_q  <= 1'b0;
      flg_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        brst_q <= reg_wdata[B_BRST];
        spr_q  <= reg_wdata[B_SPR];
      end
      pwr_q <= pwr_d;
      flg_q <= flg_d;
      irq_q <= |(flg_d & irq_en);
    end
  end

  // auxiliary RAM pointer
  always_ff @(posedge clk) begin
    if (rst)                    ptr_q <= '0;
    else if (wr_ptr)            ptr_q <= reg_wdata[RAW-1:0];
    else if (acc_data && brst_q) ptr_q <= ptr_q + 1'b1;
  end

  // read path
  logic [REG_DW-1:0] ctrl_view, rd_reg_q;
  reg_sel_e          rsel_q;

  assign ctrl_view = {batt_ok, upd_busy, brst_q, spr_q, pwr_q, flg_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q   <= SEL_NONE;
      rd_reg_q <= '0;
    end else if (reg_rd) begin
      rsel_q <= sel;
      case (sel)
        SEL_CTRL:  rd_reg_q <= ctrl_view;
        SEL_RADDR: rd_reg_q <= REG_DW'(ptr_q);
        default:   rd_reg_q <= '0;
      endcase
    end
  end

  assign reg_rdata     = (rsel_q == SEL_RDATA) ? ram_q : rd_reg_q;
  assign pwr_drive_low = ~pwr_q;
  assign irq           = irq_q;

  // R7: enabled wake/kick flag keeps power bit low
  p_pwr_forced_r7: assert property (@(posedge clk) disable iff (rst)
    ((flg_q[1] && $past(irq_en[1])) || (flg_q[0] && $past(irq_en[0])))
      |-> pwr_drive_low);
  // R10: a wake event always leaves the flag set, whatever the write
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> flg_q[1]);
  // R5: pointer holds on data access with burst off
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_data && !brst_q) |=> $stable(ptr_q));
  // R5: pointer steps by one on data access with burst on
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_data && brst_q) |=> (ptr_q == RAW'($past(ptr_q) + 1'b1)));
  // R2: control read reports the battery level
  p_batt_view_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel == SEL_CTRL) |=> (reg_rdata[B_BATT] == $past(batt_ok)));
endmodule

// File: tb/tb_rtcx_ctrl.sv
module tb_rtcx_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       batt_ok = 1'b1, upd_soon = 1'b0;
  logic       ram_clr_n = 1'b1, ram_clr_en = 1'b0;
  logic       wake_evt = 1'b0, kick_evt = 1'b0;
  logic [2:0] irq_en = '0;
  logic       pwr_drive_low, irq;

  localparam int NWIN = 7;  // LEAD_TICKS + UPD_TICKS defaults

  always #4 clk = ~clk;  // 125 MHz

  rtcx_ctrl dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .batt_ok(batt_ok),
    .upd_soon(upd_soon), .ram_clr_n(ram_clr_n), .ram_clr_en(ram_clr_en),
    .wake_evt(wake_evt), .kick_evt(kick_evt), .irq_en(irq_en),
    .pwr_drive_low(pwr_drive_low), .irq(irq));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    chk(pwr_drive_low, 1'b1, "R1 pwr");
    rd(2'd0, 8'h80, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 ptr");

    // R2/R3/R6 writable bits, read-only bits ignored
    wr(2'd0, 8'h7F);
    rd(2'd0, 8'hBF, "R2 R3 R9 ctrl after 7F");
    chk(pwr_drive_low, 1'b0, "R6 pwr released");
    chk(irq, 1'b0, "R11 no enables");
    irq_en = 3'b100;
    idle(1);
    chk(irq, 1'b1, "R11 rf enabled");
    irq_en = 3'b000;
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h80, "R9 cleared");
    chk(irq, 1'b0, "R11 cleared");
    chk(pwr_drive_low, 1'b1, "R6 pwr driven");
    batt_ok = 1'b0;
    rd(2'd0, 8'h00, "R2 battery low");
    batt_ok = 1'b1;

    // R3 reserved bit isolation
    wr(2'd0, 8'h10);
    rd(2'd0, 8'h90, "R3 spare");
    chk(irq, 1'b0, "R3 irq");
    chk(pwr_drive_low, 1'b1, "R3 pwr");
    rd(2'd1, 8'h00, "R3 ptr");

    // R5 burst with wrap
    wr(2'd1, 8'd62);
    wr(2'd0, 8'h20);
    wr(2'd2, 8'hA1);
    wr(2'd2, 8'hA2);
    wr(2'd2, 8'hA3);
    rd(2'd1, 8'd1, "R5 wrap ptr");
    wr(2'd1, 8'd62);
    rd(2'd2, 8'hA1, "R5 burst rd 62");
    rd(2'd2, 8'hA2, "R5 burst rd 63");
    rd(2'd2, 8'hA3, "R5 burst rd 0");
    rd(2'd1, 8'd1, "R5 ptr after reads");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd5);
    wr(2'd2, 8'h55);
    wr(2'd2, 8'h66);
    rd(2'd2, 8'h66, "R5 no burst overwrite");
    rd(2'd2, 8'h66, "R12 hold/reread");
    rd(2'd1, 8'd5, "R5 ptr held");
    rd(2'd3, 8'h00, "R12 unused addr");

    // R7 forced power bit
    wr(2'd0, 8'h08);
    chk(pwr_drive_low, 1'b0, "R6 pwr set");
    irq_en = 3'b010;
    wake_evt = 1'b1; idle(1); wake_evt = 1'b0;
    chk(pwr_drive_low, 1'b1, "R7 wake forces");
    chk(irq, 1'b1, "R11 wake irq");
    rd(2'd0, 8'h82, "R9 wake flag");
    wr(2'd0, 8'h0A);
    rd(2'd0, 8'h82, "R7 write blocked");
    wr(2'd0, 8'h00);
    irq_en = 3'b001;
    wr(2'd0, 8'h08);
    kick_evt = 1'b1; idle(1); kick_evt = 1'b0;
    chk(pwr_drive_low, 1'b1, "R7 kick forces");
    rd(2'd0, 8'h81, "R9 kick flag");
    wr(2'd0, 8'h00);
    irq_en = 3'b000;
    wr(2'd0, 8'h08);
    wake_evt = 1'b1; idle(1); wake_evt = 1'b0;
    rd(2'd0, 8'h8A, "R7 not enabled");
    chk(pwr_drive_low, 1'b0, "R7 pwr kept");
    chk(irq, 1'b0, "R11 disabled");
    wr(2'd0, 8'h00);

    // R8 RAM-clear edge
    ram_clr_en = 1'b1;
    ram_clr_n = 1'b0;
    idle(3);
    rd(2'd0, 8'h84, "R8 edge sets");
    wr(2'd0, 8'h00);
    idle(3);
    rd(2'd0, 8'h80, "R8 level no reset");
    ram_clr_n = 1'b1;
    idle(3);
    ram_clr_en = 1'b0;
    ram_clr_n = 1'b0;
    idle(3);
    rd(2'd0, 8'h80, "R8 disabled");
    ram_clr_n = 1'b1;
    idle(3);

    // R10 set beats clear
    reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1; wake_evt = 1'b1;
    idle(1);
    reg_wr = 1'b0; wake_evt = 1'b0;
    rd(2'd0, 8'h82, "R10 set wins");
    wr(2'd0, 8'h00);

    // R4 update window
    upd_soon = 1'b1; idle(1); upd_soon = 1'b0;
    for (int k = 1; k <= NWIN + 2; k++) begin
      upd_soon = (k == 3);
      rd(2'd0, (k <= NWIN) ? 8'hC0 : 8'h80, $sformatf("R4 window k=%0d", k));
    end
    upd_soon = 1'b0;
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule